// File: doc/BRIEF.md
# Store Queue with Load Hazard Resolution

This block keeps the stores that a core has issued but not yet committed, in program order, in a circular queue. Each store is given an entry when it issues. Its address and its value reach the queue later, on two separate write ports and in either order. A load captures the queue's allocation pointer when it issues, and that pointer is the load's age. Every queue entry between the head and that age is older than the load.

When the load's address is known, the block presents the address and the age on the lookup port. In the same cycle the block returns one of four verdicts. The load must stall if some older store has no address yet. If the youngest older store with the same address has its value, that value is forwarded. If that store's value is still missing, its reorder-buffer tag is returned so that the load can wait for the producer. Otherwise the load may go to memory. Committed stores leave from the head in order and appear on the retire port. A flush rewinds the allocation pointer to a given position, which discards every entry at or after it.

Top module: `store_queue_disamb`

## Requirements
- R1: While the queue is not full and no flush is requested, an allocation takes the entry at `alloc_ptr`, records its tag and advances `alloc_ptr` by one modulo 2·DEPTH. An allocation while full is ignored.
- R2: The address and the value of an occupied entry are written independently through their own index ports, each setting its own valid flag, and the allocation of an entry clears both flags.
- R3: `ld_result` is coded 2'b00 memory, 2'b01 stall, 2'b10 forward, 2'b11 tag. If any store older than the load lacks its address, the result is stall, even when an older matching store exists.
- R4: With all older addresses known, if the youngest older store whose address equals `ld_addr` has its value, the result is forward and `ld_data` carries that value.
- R5: If that youngest older matching store has no value yet, the result is tag and `ld_tag` carries its tag, even when an older match has a value.
- R6: If no older store matches, or the queue is empty, or `ld_valid` is low, the result is memory. Stores at or after the load's age are never considered.
- R7: A commit retires the head entry only when both its address and its value are valid. It then drives `retire_valid` with that entry's address and value for the cycle and advances the head. Otherwise the commit is ignored.
- R8: A flush sets `alloc_ptr` to `flush_tail` on the next cycle, which discards all entries from that position on. Allocation in the same cycle is ignored.
- R9: After reset the queue is empty with both pointers at zero. `sq_full` and `sq_empty` follow the occupancy exactly and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry for an issuing store |
| alloc_tag | input | TAG_W | Reorder-buffer tag of the issuing store |
| alloc_ptr | output | PTR_W | Pointer of the next entry to allocate (with wrap bit) |
| sq_full | output | 1 | All DEPTH entries occupied |
| sq_empty | output | 1 | No entry occupied |
| addr_wr_valid | input | 1 | Store address arrives |
| addr_wr_idx | input | IDX_W | Entry receiving the address |
| addr_wr_addr | input | ADDR_W | Store address |
| data_wr_valid | input | 1 | Store value arrives |
| data_wr_idx | input | IDX_W | Entry receiving the value |
| data_wr_data | input | DATA_W | Store value |
| ld_valid | input | 1 | Load lookup request |
| ld_age | input | PTR_W | Pointer the load captured at issue |
| ld_addr | input | ADDR_W | Load address |
| ld_result | output | 2 | Lookup verdict |
| ld_data | output | DATA_W | Forwarded value (zero unless forward) |
| ld_tag | output | TAG_W | Producer tag (zero unless tag) |
| commit_valid | input | 1 | Commit the head store |
| retire_valid | output | 1 | Head store leaves the queue this cycle |
| retire_addr | output | ADDR_W | Address of the retiring store |
| retire_data | output | DATA_W | Value of the retiring store |
| flush_valid | input | 1 | Discard younger entries |
| flush_tail | input | PTR_W | New allocation pointer after the flush |

## Verification
The assertions check the pointer behaviour on every cycle. They cover the exclusion of full and empty, the hold of the allocation pointer while full, its single step on an allocation, the jump on a flush, the head step on retirement, no retirement from an empty queue, and the memory verdict for any lookup into an empty queue. Other behaviours need a history of stores and are shown only by the bench's scenarios. These are the choice of the youngest older match, the priority of stall over a match, tag versus forward, the exclusion of younger stores, and a commit that is refused because the head store is incomplete.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam logic [1:0] RES_MEM   = 2'b00;
  localparam logic [1:0] RES_STALL = 2'b01;
  localparam logic [1:0] RES_FWD   = 2'b10;
  localparam logic [1:0] RES_TAG   = 2'b11;
endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             commit_req,
  input  logic             head_ready,
  input  logic             flush_req,
  input  logic [PTR_W-1:0] flush_ptr,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             alloc_fire,
  output logic             commit_fire,
  output logic [DEPTH-1:0] occupied
);
  // occupancy is the wrapped pointer distance
  function automatic logic [PTR_W-1:0] ptr_dist(logic [PTR_W-1:0] a, logic [PTR_W-1:0] b);
    return a - b;
  endfunction

  assign count       = ptr_dist(tail, head);
  assign full        = (count == PTR_W'(DEPTH));
  assign empty       = (count == '0);
  assign alloc_fire  = alloc_req && !full && !flush_req;
  assign commit_fire = commit_req && !empty && head_ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    logic [IDX_W-1:0] offs;
    assign offs        = IDX_W'(g) - head[IDX_W-1:0];
    assign occupied[g] = ({1'b0, offs} < count);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (commit_fire) head <= head + PTR_W'(1);
      if (flush_req)       tail <= flush_ptr;
      else if (alloc_fire) tail <= tail + PTR_W'(1);
    end
  end
endmodule

// File: rtl/sq_entries.sv
module sq_entries #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              aw_en,
  input  logic [IDX_W-1:0]  aw_idx,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              dw_en,
  input  logic [IDX_W-1:0]  dw_idx,
  input  logic [DATA_W-1:0] dw_data,
  input  logic [DEPTH-1:0]  occupied,
  output logic [ADDR_W-1:0] e_addr [DEPTH],
  output logic [DATA_W-1:0] e_data [DEPTH],
  output logic [TAG_W-1:0]  e_tag  [DEPTH],
  output logic [DEPTH-1:0]  e_av,
  output logic [DEPTH-1:0]  e_dv
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic take_alloc, take_addr, take_data;
    assign take_alloc = alloc_fire && (alloc_idx == IDX_W'(g));
    assign take_addr  = aw_en && (aw_idx == IDX_W'(g)) && occupied[g];
    assign take_data  = dw_en && (dw_idx == IDX_W'(g)) && occupied[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_addr[g] <= '0;
        e_data[g] <= '0;
        e_tag[g]  <= '0;
        e_av[g]   <= 1'b0;
        e_dv[g]   <= 1'b0;
      end else begin
        if (take_alloc) begin
          e_tag[g] <= alloc_tag;
          e_av[g]  <= 1'b0;
          e_dv[g]  <= 1'b0;
        end
        if (take_addr) begin
          e_addr[g] <= aw_addr;
          e_av[g]   <= 1'b1;
        end
        if (take_data) begin
          e_data[g] <= dw_data;
          e_dv[g]   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sq_search.sv
module sq_search #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              ld_valid,
  input  logic [PTR_W-1:0]  ld_age,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W-1:0]  count,
  input  logic [ADDR_W-1:0] e_addr [DEPTH],
  input  logic [DATA_W-1:0] e_data [DEPTH],
  input  logic [TAG_W-1:0]  e_tag  [DEPTH],
  input  logic [DEPTH-1:0]  e_av,
  input  logic [DEPTH-1:0]  e_dv,
  output logic [1:0]        result,
  output logic [DATA_W-1:0] fwd_data,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic              stall_any,
  output logic              hit_any
);
  import sq_pkg::*;

  // number of entries older than the load; zero once the head has passed its age
  function automatic logic [PTR_W-1:0] older_span(logic [PTR_W-1:0] age, logic [PTR_W-1:0] hd,
                                                  logic [PTR_W-1:0] cnt);
    logic [PTR_W-1:0] d;
    d = age - hd;
    return (d > cnt) ? '0 : d;
  endfunction

  logic [PTR_W-1:0] older;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] idx;

  always_comb begin
    older     = older_span(ld_age, head, count);
    stall_any = 1'b0;
    hit_any   = 1'b0;
    hit_idx   = '0;
    idx       = '0;
    // walk oldest to youngest so the last match is the youngest
    for (int k = 0; k < DEPTH; k++) begin
      idx = head[IDX_W-1:0] + IDX_W'(k);
      if (PTR_W'(k) < older) begin
        if (!e_av[idx]) begin
          stall_any = 1'b1;
        end else if (e_addr[idx] == ld_addr) begin
          hit_any = 1'b1;
          hit_idx = idx;
        end
      end
    end
  end

  always_comb begin
    result   = RES_MEM;
    fwd_data = '0;
    fwd_tag  = '0;
    if (ld_valid) begin
      if (stall_any) begin
        result = RES_STALL;
      end else if (hit_any) begin
        if (e_dv[hit_idx]) begin
          result   = RES_FWD;
          fwd_data = e_data[hit_idx];
        end else begin
          result  = RES_TAG;
          fwd_tag = e_tag[hit_idx];
        end
      end
    end
  end
endmodule

// File: rtl/store_queue_disamb.sv
module store_queue_disamb #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic [PTR_W-1:0]  alloc_ptr,
  output logic              sq_full,
  output logic              sq_empty,
  input  logic              addr_wr_valid,
  input  logic [IDX_W-1:0]  addr_wr_idx,
  input  logic [ADDR_W-1:0] addr_wr_addr,
  input  logic              data_wr_valid,
  input  logic [IDX_W-1:0]  data_wr_idx,
  input  logic [DATA_W-1:0] data_wr_data,
  input  logic              ld_valid,
  input  logic [PTR_W-1:0]  ld_age,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [1:0]        ld_result,
  output logic [DATA_W-1:0] ld_data,
  output logic [TAG_W-1:0]  ld_tag,
  input  logic              commit_valid,
  output logic              retire_valid,
  output logic [ADDR_W-1:0] retire_addr,
  output logic [DATA_W-1:0] retire_data,
  input  logic              flush_valid,
  input  logic [PTR_W-1:0]  flush_tail
);
  logic [PTR_W-1:0]  head_ptr, tail_ptr, occ_count;
  logic              alloc_fire, commit_fire, head_ready;
  logic [DEPTH-1:0]  occupied;
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  logic [TAG_W-1:0]  e_tag  [DEPTH];
  logic [DEPTH-1:0]  e_av, e_dv;
  logic              stall_any, hit_any;
  logic [IDX_W-1:0]  head_idx;

  assign head_idx   = head_ptr[IDX_W-1:0];
  assign head_ready = e_av[head_idx] && e_dv[head_idx];

  sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_valid),
    .commit_req (commit_valid),
    .head_ready (head_ready),
    .flush_req  (flush_valid),
    .flush_ptr  (flush_tail),
    .head       (head_ptr),
    .tail       (tail_ptr),
    .count      (occ_count),
    .full       (sq_full),
    .empty      (sq_empty),
    .alloc_fire (alloc_fire),
    .commit_fire(commit_fire),
    .occupied   (occupied)
  );

  sq_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_fire(alloc_fire),
    .alloc_idx (tail_ptr[IDX_W-1:0]),
    .alloc_tag (alloc_tag),
    .aw_en     (addr_wr_valid),
    .aw_idx    (addr_wr_idx),
    .aw_addr   (addr_wr_addr),
    .dw_en     (data_wr_valid),
    .dw_idx    (data_wr_idx),
    .dw_data   (data_wr_data),
    .occupied  (occupied),
    .e_addr    (e_addr),
    .e_data    (e_data),
    .e_tag     (e_tag),
    .e_av      (e_av),
    .e_dv      (e_dv)
  );

  sq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_search (
    .ld_valid (ld_valid),
    .ld_age   (ld_age),
    .ld_addr  (ld_addr),
    .head     (head_ptr),
    .count    (occ_count),
    .e_addr   (e_addr),
    .e_data   (e_data),
    .e_tag    (e_tag),
    .e_av     (e_av),
    .e_dv     (e_dv),
    .result   (ld_result),
    .fwd_data (ld_data),
    .fwd_tag  (ld_tag),
    .stall_any(stall_any),
    .hit_any  (hit_any)
  );

  assign alloc_ptr    = tail_ptr;
  assign retire_valid = commit_fire;
  assign retire_addr  = commit_fire ? e_addr[head_idx] : '0;
  assign retire_data  = commit_fire ? e_data[head_idx] : '0;
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              sq_full,
  input logic              sq_empty,
  input logic [PTR_W-1:0]  alloc_ptr,
  input logic [PTR_W-1:0]  head_ptr,
  input logic              flush_valid,
  input logic [PTR_W-1:0]  flush_tail,
  input logic              retire_valid,
  input logic              ld_valid,
  input logic [1:0]        ld_result
);
  p_full_empty_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_full && sq_empty));

  p_alloc_hold_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sq_full && !flush_valid |=> $stable(alloc_ptr));

  p_alloc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !sq_full && !flush_valid |=> alloc_ptr == $past(alloc_ptr) + PTR_W'(1));

  p_flush_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> alloc_ptr == $past(flush_tail));

  p_retire_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> head_ptr == $past(head_ptr) + PTR_W'(1));

  p_no_retire_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sq_empty |-> !retire_valid);

  p_empty_goes_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sq_empty && ld_valid |-> ld_result == sq_pkg::RES_MEM);
endmodule

bind store_queue_disamb sq_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_sq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .sq_full     (sq_full),
  .sq_empty    (sq_empty),
  .alloc_ptr   (alloc_ptr),
  .head_ptr    (head_ptr),
  .flush_valid (flush_valid),
  .flush_tail  (flush_tail),
  .retire_valid(retire_valid),
  .ld_valid    (ld_valid),
  .ld_result   (ld_result)
);

// File: tb/store_queue_disamb_bench.sv
module store_queue_disamb_bench;
  localparam int D = 8, AW = 16, DW = 32, TW = 6, IW = 3, PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          alloc_valid, addr_wr_valid, data_wr_valid, ld_valid, commit_valid, flush_valid;
  logic [TW-1:0] alloc_tag, ld_tag;
  logic [PW-1:0] alloc_ptr, ld_age, flush_tail;
  logic          sq_full, sq_empty, retire_valid;
  logic [IW-1:0] addr_wr_idx, data_wr_idx;
  logic [AW-1:0] addr_wr_addr, ld_addr, retire_addr;
  logic [DW-1:0] data_wr_data, ld_data, retire_data;
  logic [1:0]    ld_result;

  store_queue_disamb u_store_queue_disamb (.*);

  int checks = 0, errors = 0;

  // reference state, indexed by entry; pointers kept as unbounded sequence numbers
  logic [AW-1:0] m_addr [D];
  logic [DW-1:0] m_data [D];
  logic [TW-1:0] m_tag  [D];
  bit            m_av [D];
  bit            m_dv [D];
  int            m_head = 0, m_tail = 0;

  // stimulus of the current cycle
  bit d_alloc, d_aw, d_dw, d_ld, d_commit, d_flush;
  int d_atag, d_aidx, d_didx, d_lage, d_fseq;
  logic [AW-1:0] d_aaddr, d_laddr;
  logic [DW-1:0] d_ddata;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit occ(int idx);
    for (int s = m_head; s < m_tail; s++) if (s % D == idx) return 1;
    return 0;
  endfunction

  function automatic void exp_lookup(int age, logic [AW-1:0] a, output logic [1:0] res,
                                     output logic [DW-1:0] dat, output logic [TW-1:0] tg);
    bit st = 0;
    int hit = -1;
    res = 2'b00; dat = '0; tg = '0;
    if (!d_ld) return;
    for (int s = m_head; s < age; s++) begin
      if (!m_av[s % D]) st = 1;
      else if (m_addr[s % D] == a) hit = s % D;
    end
    if (st) res = 2'b01;
    else if (hit >= 0) begin
      if (m_dv[hit]) begin res = 2'b10; dat = m_data[hit]; end
      else begin res = 2'b11; tg = m_tag[hit]; end
    end
  endfunction

  task automatic step();
    logic [1:0] er; logic [DW-1:0] ed; logic [TW-1:0] et;
    bit cfire, afire;
    string rq;
    alloc_valid = d_alloc; alloc_tag = TW'(d_atag);
    addr_wr_valid = d_aw; addr_wr_idx = IW'(d_aidx); addr_wr_addr = d_aaddr;
    data_wr_valid = d_dw; data_wr_idx = IW'(d_didx); data_wr_data = d_ddata;
    ld_valid = d_ld; ld_age = PW'(d_lage % (2 * D)); ld_addr = d_laddr;
    commit_valid = d_commit; flush_valid = d_flush; flush_tail = PW'(d_fseq % (2 * D));
    #1;
    chk(alloc_ptr == PW'(m_tail % (2 * D)), "R1 alloc_ptr", 64'(alloc_ptr), 64'(m_tail % (2 * D)));
    chk(sq_full == (m_tail - m_head == D), "R9 full", 64'(sq_full), 64'(m_tail - m_head == D));
    chk(sq_empty == (m_tail == m_head), "R9 empty", 64'(sq_empty), 64'(m_tail == m_head));
    exp_lookup(d_lage, d_laddr, er, ed, et);
    case (er)
      2'b01:   rq = "R3 stall";
      2'b10:   rq = "R4/R2 forward";
      2'b11:   rq = "R5 tag";
      default: rq = "R6 memory";
    endcase
    chk(ld_result == er, rq, 64'(ld_result), 64'(er));
    chk(ld_data == ed, rq, 64'(ld_data), 64'(ed));
    chk(ld_tag == et, rq, 64'(ld_tag), 64'(et));
    cfire = d_commit && (m_tail > m_head) && m_av[m_head % D] && m_dv[m_head % D];
    chk(retire_valid == cfire, "R7 retire_valid", 64'(retire_valid), 64'(cfire));
    if (cfire) begin
      chk(retire_addr == m_addr[m_head % D], "R7 retire_addr", 64'(retire_addr), 64'(m_addr[m_head % D]));
      chk(retire_data == m_data[m_head % D], "R7 retire_data", 64'(retire_data), 64'(m_data[m_head % D]));
    end
    // advance the reference
    afire = d_alloc && (m_tail - m_head < D) && !d_flush;
    if (d_aw && occ(d_aidx)) begin m_addr[d_aidx] = d_aaddr; m_av[d_aidx] = 1; end
    if (d_dw && occ(d_didx)) begin m_data[d_didx] = d_ddata; m_dv[d_didx] = 1; end
    if (afire) begin
      m_av[m_tail % D] = 0; m_dv[m_tail % D] = 0; m_tag[m_tail % D] = TW'(d_atag);
      m_tail++;
    end
    if (cfire) m_head++;
    if (d_flush) m_tail = d_fseq;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    d_alloc = 0; d_aw = 0; d_dw = 0; d_ld = 0; d_commit = 0; d_flush = 0;
    d_atag = 0; d_aidx = 0; d_didx = 0; d_lage = m_head; d_fseq = 0;
    d_aaddr = '0; d_laddr = '0; d_ddata = '0;
  endtask

  task automatic load(int age, logic [AW-1:0] a);
    idle(); d_ld = 1; d_lage = age; d_laddr = a; step();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < D; i++) begin
      m_addr[i] = '0; m_data[i] = '0; m_tag[i] = '0; m_av[i] = 0; m_dv[i] = 0;
    end
    idle();
    alloc_valid = 0; addr_wr_valid = 0; data_wr_valid = 0; ld_valid = 0;
    commit_valid = 0; flush_valid = 0; alloc_tag = '0; addr_wr_idx = '0; data_wr_idx = '0;
    addr_wr_addr = '0; data_wr_data = '0; ld_age = '0; ld_addr = '0; flush_tail = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: reset state, lookup on empty queue
    load(0, 16'h0100);

    // R1: fill up, then one more allocation while full
    for (int i = 0; i < D + 1; i++) begin
      idle(); d_alloc = 1; d_atag = 10 + i; step();
    end
    chk(sq_full == 1'b1, "R1 full after DEPTH allocations", 64'(sq_full), 64'd1);

    // R3: entry 1 has no address yet, entry 0 matches
    idle(); d_aw = 1; d_aidx = 0; d_aaddr = 16'h0100; step();
    load(2, 16'h0100);
    // R5: youngest older match without value
    idle(); d_aw = 1; d_aidx = 1; d_aaddr = 16'h0200; step();
    load(2, 16'h0100);
    // R4: value arrives for entry 0
    idle(); d_dw = 1; d_didx = 0; d_ddata = 32'hCAFE0001; step();
    load(2, 16'h0100);
    // R5: younger matching entry 2 without value wins over entry 0
    idle(); d_aw = 1; d_aidx = 2; d_aaddr = 16'h0100; step();
    load(3, 16'h0100);
    // R6: entry 2 lies at the load's age, so it is not considered
    load(2, 16'h0100);
    load(3, 16'h0300);
    // R7: head complete retires, then the next head lacks a value
    idle(); d_commit = 1; step();
    idle(); d_commit = 1; step();
    // R8: rewind to sequence 4
    idle(); d_flush = 1; d_fseq = 4; d_alloc = 1; step();
    chk(alloc_ptr == PW'(4), "R8 alloc_ptr after flush", 64'(alloc_ptr), 64'd4);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      idle();
      d_alloc = ($urandom % 3) != 0;
      d_atag  = int'($urandom % 64);
      d_aw    = $urandom % 2; d_aidx = int'($urandom % D);
      d_aaddr = AW'(16'h0100 + ($urandom % 4) * 4);
      d_dw    = $urandom % 2; d_didx = int'($urandom % D);
      d_ddata = $urandom;
      d_commit = ($urandom % 3) == 0;
      d_ld    = $urandom % 2;
      d_lage  = m_head + int'($urandom % (m_tail - m_head + 1));
      d_laddr = AW'(16'h0100 + ($urandom % 4) * 4);
      if ($urandom % 40 == 0) begin
        d_flush = 1; d_commit = 0;
        d_fseq = m_head + int'($urandom % (m_tail - m_head + 1));
      end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule